// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Default-Master Policies

This block decides which of up to sixteen bus masters owns one slave port of a multi-master interconnect. Each master raises a request line. The master that currently holds the port reports the state of its access: whether it is moving data, whether the access is a single transfer or a burst, whether the current beat is the last of a defined-length burst, and whether the burst has undefined length. The block drives a registered one-hot grant vector, or all zeros when no master owns the port.

Ownership can change only at points where breaking in is safe. These points are an idle cycle, a single-access cycle, the closing beat of a burst, and the cycle in which a slot counter shows that the current owner has held the port too long. At such a point a waiting request is served by round-robin or by fixed priority. When nobody is asking, a configurable default policy decides what happens: the port is released, it stays with the most recent winner, or it is parked on a chosen master. All configuration arrives on plain input ports that a register file drives.

Top module: `slave_arbiter`

## Requirements
- R1: After reset the grant is all zeros, and at every cycle at most one grant bit is set.
- R2: The grant is registered. It takes a new value one clock after a cycle that is an arbitration point and holds its value after every other cycle.
- R3: A cycle is an arbitration point when no master is granted, when `acc_busy` is 0 (idle), or when `acc_busy` is 1 and `acc_burst` is 0 (single access).
- R4: During a defined-length burst (`acc_busy`=1, `acc_burst`=1, `acc_undef`=0), only the beat with `acc_last`=1 is an end-of-burst arbitration point.
- R5: During an undefined-length burst (`acc_undef`=1), `acc_last` is ignored. The burst ends in the cycle where the granted master's request bit is 0.
- R6: A slot counter is cleared at every arbitration point and counts up by one, saturating at 255, in each other cycle. A cycle whose count is at least `cfg_slot_limit` is an arbitration point. A limit of 0 disables this rule.
- R7: With `cfg_arb_alg`=0 (round-robin, the value used after reset), the winner is the first requesting master found by searching upward from one above the last request winner and wrapping at the top. With no earlier winner the search starts at master 0.
- R8: With `cfg_arb_alg`=1 (fixed priority), the requesting master with the lowest index wins.
- R9: With `cfg_dflt_mode` 0 (none) or 3 (treated as none), an arbitration point with no request leaves the grant all zeros.
- R10: With `cfg_dflt_mode`=1 (last access), an arbitration point with no request grants the most recent request winner, or nobody if there has been none. `cfg_dflt_idx` has no effect in this mode.
- R11: With `cfg_dflt_mode`=2 (fixed default), an arbitration point with no request grants master `cfg_dflt_idx`. A rewrite of the field takes effect at the next such point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_req | input | N_MASTERS | Request line of each master |
| acc_busy | input | 1 | The granted master is transferring in this cycle |
| acc_burst | input | 1 | 1 = burst access, 0 = single access |
| acc_last | input | 1 | Last beat of a defined-length burst |
| acc_undef | input | 1 | The burst has undefined length |
| cfg_arb_alg | input | 1 | 0 = round-robin, 1 = fixed priority |
| cfg_dflt_mode | input | 2 | 0 = none, 1 = last access, 2 = fixed default, 3 = none |
| cfg_dflt_idx | input | IDX_W | Master that is parked on the port in fixed-default mode |
| cfg_slot_limit | input | LIMIT_W | Slot cycle limit, 0 disables it |
| gnt | output | N_MASTERS | One-hot grant, or all zeros |

## Verification
A wrong last-winner record does not show up at once. It appears at the next arbitration point that has no request in last-access mode, where the port parks on the wrong master, or at the next contended round-robin decision, where the wrong master wins. Both become visible on `gnt` one clock after that point. A slot counter that is off by one shifts a forced break by exactly one cycle, so long bursts are run against small limits and the grant is checked on every cycle. A wrongly detected arbitration point shows up on the following edge, as a grant that moves in the middle of a burst or stays stuck after the burst's closing beat.

// File: rtl/slvarb_pkg.sv
package slvarb_pkg;

  typedef enum logic {
    ALG_ROUND_ROBIN = 1'b0,
    ALG_FIXED_PRIO  = 1'b1
  } arb_alg_e;

  typedef enum logic [1:0] {
    DM_NONE  = 2'd0,
    DM_LAST  = 2'd1,
    DM_FIXED = 2'd2,
    DM_RSVD  = 2'd3
  } dflt_mode_e;

endpackage

// File: rtl/slvarb_slot_timer.sv
module slvarb_slot_timer #(
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               run,
  input  logic [LIMIT_W-1:0] limit,
  output logic               hit
);
  localparam logic [LIMIT_W-1:0] CNT_MAX = '1;

  logic [LIMIT_W-1:0] cnt_q;

  function automatic logic [LIMIT_W-1:0] sat_inc(input logic [LIMIT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (take)   cnt_q <= '0;
    else if (run)    cnt_q <= sat_inc(cnt_q);
  end

  assign hit = (limit != '0) && (cnt_q >= limit);

  // R6
  slot_no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !hit);

  // R6
  slot_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0) |-> !hit);

endmodule

// File: rtl/slvarb_point.sv
module slvarb_point (
  input  logic gnt_any,
  input  logic owner_req,
  input  logic busy,
  input  logic burst,
  input  logic last,
  input  logic undef,
  input  logic slot_hit,
  output logic ev_idle,
  output logic ev_single,
  output logic ev_eob,
  output logic take
);
  function automatic logic burst_closes(input logic is_undef, input logic beat_last,
                                        input logic still_req);
    return is_undef ? !still_req : beat_last;
  endfunction

  always_comb begin
    ev_idle   = !gnt_any || !busy;
    ev_single = busy && !burst;
    ev_eob    = busy && burst && burst_closes(undef, last, owner_req);
    take      = ev_idle || ev_single || ev_eob || slot_hit;
  end

endmodule

// File: rtl/slvarb_pick.sv
module slvarb_pick
  import slvarb_pkg::*;
#(
  parameter int N_MASTERS = 16,
  parameter int IDX_W     = 4
) (
  input  logic [N_MASTERS-1:0] req,
  input  arb_alg_e             alg,
  input  logic [IDX_W-1:0]     last_idx,
  input  logic                 last_vld,
  input  dflt_mode_e           mode,
  input  logic [IDX_W-1:0]     dflt_idx,
  output logic [N_MASTERS-1:0] nxt_gnt,
  output logic [IDX_W-1:0]     win_idx,
  output logic                 win_vld
);
  function automatic logic [N_MASTERS-1:0] one_hot(input logic [IDX_W-1:0] idx);
    logic [N_MASTERS-1:0] v;
    v = '0;
    if (int'(idx) < N_MASTERS) v[idx] = 1'b1;
    return v;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_MASTERS-1:0] r);
    logic [IDX_W-1:0] found;
    found = '0;
    for (int i = N_MASTERS - 1; i >= 0; i--) begin
      if (r[i]) found = IDX_W'(i);
    end
    return found;
  endfunction

  function automatic logic [IDX_W-1:0] rotate_pick(input logic [N_MASTERS-1:0] r,
                                                    input int base);
    logic [IDX_W-1:0] found;
    logic             seen;
    found = '0;
    seen  = 1'b0;
    for (int k = 0; k < N_MASTERS; k++) begin
      int pos;
      pos = (base + k) % N_MASTERS;
      if (!seen && r[pos]) begin
        found = IDX_W'(pos);
        seen  = 1'b1;
      end
    end
    return found;
  endfunction

  int rr_base;

  always_comb begin
    rr_base = last_vld ? (int'(last_idx) + 1) % N_MASTERS : 0;
    win_vld = |req;
    win_idx = (alg == ALG_FIXED_PRIO) ? lowest_set(req) : rotate_pick(req, rr_base);
    if (win_vld) begin
      nxt_gnt = one_hot(win_idx);
    end else begin
      unique case (mode)
        DM_LAST:  nxt_gnt = last_vld ? one_hot(last_idx) : '0;
        DM_FIXED: nxt_gnt = one_hot(dflt_idx);
        default:  nxt_gnt = '0;
      endcase
    end
  end

endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter
  import slvarb_pkg::*;
#(
  parameter int N_MASTERS = 16,
  parameter int LIMIT_W   = 8,
  localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_MASTERS-1:0] mst_req,
  input  logic                 acc_busy,
  input  logic                 acc_burst,
  input  logic                 acc_last,
  input  logic                 acc_undef,
  input  logic                 cfg_arb_alg,
  input  logic [1:0]           cfg_dflt_mode,
  input  logic [IDX_W-1:0]     cfg_dflt_idx,
  input  logic [LIMIT_W-1:0]   cfg_slot_limit,
  output logic [N_MASTERS-1:0] gnt
);
  localparam logic [N_MASTERS-1:0] ONE_VEC = {{(N_MASTERS-1){1'b0}}, 1'b1};

  logic [N_MASTERS-1:0] gnt_q;
  logic [IDX_W-1:0]     last_idx_q;
  logic                 last_vld_q;

  logic                 gnt_any, owner_req, slot_hit;
  logic                 ev_idle, ev_single, ev_eob, arb_take;
  logic [N_MASTERS-1:0] nxt_gnt;
  logic [IDX_W-1:0]     win_idx;
  logic                 win_vld;
  arb_alg_e             alg;
  dflt_mode_e           mode;

  assign alg       = arb_alg_e'(cfg_arb_alg);
  assign mode      = dflt_mode_e'(cfg_dflt_mode);
  assign gnt_any   = |gnt_q;
  assign owner_req = |(mst_req & gnt_q);

  slvarb_slot_timer #(.LIMIT_W(LIMIT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (arb_take),
    .run   (acc_busy),
    .limit (cfg_slot_limit),
    .hit   (slot_hit)
  );

  slvarb_point u_point (
    .gnt_any   (gnt_any),
    .owner_req (owner_req),
    .busy      (acc_busy),
    .burst     (acc_burst),
    .last      (acc_last),
    .undef     (acc_undef),
    .slot_hit  (slot_hit),
    .ev_idle   (ev_idle),
    .ev_single (ev_single),
    .ev_eob    (ev_eob),
    .take      (arb_take)
  );

  slvarb_pick #(.N_MASTERS(N_MASTERS), .IDX_W(IDX_W)) u_pick (
    .req      (mst_req),
    .alg      (alg),
    .last_idx (last_idx_q),
    .last_vld (last_vld_q),
    .mode     (mode),
    .dflt_idx (cfg_dflt_idx),
    .nxt_gnt  (nxt_gnt),
    .win_idx  (win_idx),
    .win_vld  (win_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q      <= '0;
      last_idx_q <= '0;
      last_vld_q <= 1'b0;
    end else if (arb_take) begin
      gnt_q <= nxt_gnt;
      if (win_vld) begin
        last_idx_q <= win_idx;
        last_vld_q <= 1'b1;
      end
    end
  end

  assign gnt = gnt_q;

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));

  // R2
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_take |=> $stable(gnt_q));

  // R3
  idle_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_busy || (acc_busy && !acc_burst)) |-> arb_take);

  // R4
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && acc_busy && acc_burst && !acc_undef && !acc_last && !slot_hit)
      |=> $stable(gnt_q));

  // R5
  undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && acc_busy && acc_burst && acc_undef && owner_req && !slot_hit)
      |=> $stable(gnt_q));

  // R7
  served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_take && (|mst_req)) |=> ((gnt_q & $past(mst_req)) != '0));

  // R8
  prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_take && (|mst_req) && cfg_arb_alg)
      |=> (((gnt_q - ONE_VEC) & $past(mst_req)) == '0));

  // R9
  no_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_take && !(|mst_req) && (cfg_dflt_mode[1] == cfg_dflt_mode[0]))
      |=> (gnt_q == '0));

  // R11
  fixed_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_take && !(|mst_req) && (cfg_dflt_mode == 2'd2))
      |=> (gnt_q == (ONE_VEC << $past(cfg_dflt_idx))));

endmodule

// File: tb/test_slave_arbiter.sv
module test_slave_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 16;
  localparam int LIM_MAX = 255;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NM-1:0] mst_req;
  logic          acc_busy, acc_burst, acc_last, acc_undef;
  logic          cfg_arb_alg;
  logic [1:0]    cfg_dflt_mode;
  logic [3:0]    cfg_dflt_idx;
  logic [7:0]    cfg_slot_limit;
  logic [NM-1:0] gnt;

  int tests = 0;
  int fails = 0;

  int    m_gnt;
  int    m_last;
  int    m_cnt;
  string m_tag;
  string force_tag = "";

  slave_arbiter i_slave_arbiter (
    .clk(clk), .rst_n(rst_n), .mst_req(mst_req),
    .acc_busy(acc_busy), .acc_burst(acc_burst), .acc_last(acc_last), .acc_undef(acc_undef),
    .cfg_arb_alg(cfg_arb_alg), .cfg_dflt_mode(cfg_dflt_mode), .cfg_dflt_idx(cfg_dflt_idx),
    .cfg_slot_limit(cfg_slot_limit), .gnt(gnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int pick_rr(input logic [NM-1:0] r, input int prev);
    int start;
    start = (prev < 0) ? NM - 1 : prev;
    for (int k = 1; k <= NM; k++) begin
      if (r[(start + k) % NM]) return (start + k) % NM;
    end
    return -1;
  endfunction

  function automatic int pick_low(input logic [NM-1:0] r);
    for (int i = 0; i < NM; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic logic [NM-1:0] vec_of(input int idx);
    logic [NM-1:0] v;
    v = '0;
    if (idx >= 0 && idx < NM) v[idx] = 1'b1;
    return v;
  endfunction

  // Reference model, advanced on every rising edge from the inputs held there.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gnt  = -1;
      m_last = -1;
      m_cnt  = 0;
      m_tag  = "R1";
    end else begin
      bit idle, single, eob, slot, arb;
      idle   = (m_gnt < 0) || !acc_busy;
      single = acc_busy && !acc_burst;
      eob    = acc_busy && acc_burst &&
               (acc_undef ? (m_gnt < 0 || !mst_req[m_gnt]) : acc_last);
      slot   = (cfg_slot_limit != 0) && (m_cnt >= int'(cfg_slot_limit));
      arb    = idle || single || eob || slot;
      if (arb) begin
        m_cnt = 0;
        if (mst_req != '0) begin
          m_gnt  = cfg_arb_alg ? pick_low(mst_req) : pick_rr(mst_req, m_last);
          m_last = m_gnt;
          m_tag  = cfg_arb_alg ? "R8" : "R7";
        end else if (cfg_dflt_mode == 2'd1) begin
          m_gnt = m_last;
          m_tag = "R10";
        end else if (cfg_dflt_mode == 2'd2) begin
          m_gnt = int'(cfg_dflt_idx);
          m_tag = "R11";
        end else begin
          m_gnt = -1;
          m_tag = "R9";
        end
      end else begin
        m_cnt = (m_cnt < LIM_MAX) ? m_cnt + 1 : LIM_MAX;
        m_tag = "R2";
      end
    end
  end

  task automatic tick();
    string tg;
    @(posedge clk);
    @(negedge clk);
    tests++;
    tg = (force_tag != "") ? force_tag : m_tag;
    if (gnt !== vec_of(m_gnt)) begin
      fails++;
      $display("FAIL %s gnt=%h expected=%h at %0t", tg, gnt, vec_of(m_gnt), $time);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_acc(input logic b, input logic bu, input logic l, input logic u);
    acc_busy = b; acc_burst = bu; acc_last = l; acc_undef = u;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; mst_req = '0; set_acc(0, 0, 0, 0);
    cfg_arb_alg = 1'b0; cfg_dflt_mode = 2'd0; cfg_dflt_idx = 4'd0; cfg_slot_limit = 8'd0;
    repeat (3) @(negedge clk);
    tests++;
    if (gnt !== '0) begin
      fails++;
      $display("FAIL R1 reset gnt=%h expected=%h", gnt, 16'h0);
    end
    rst_n = 1'b1;

    // Idle and single cycles are arbitration points.
    force_tag = "R3";
    mst_req = 16'h0001; tick();
    set_acc(1, 0, 0, 0); mst_req = 16'h0003; ticks(3);

    // Defined-length burst held until its closing beat.
    force_tag = "R4";
    set_acc(1, 1, 0, 0); ticks(4);
    acc_last = 1'b1; tick();
    acc_last = 1'b0; ticks(3);

    // Undefined-length burst ignores the last flag, ends when request drops.
    force_tag = "R5";
    set_acc(1, 1, 1, 1); ticks(4);
    mst_req = (gnt == 16'h0002) ? 16'h0001 : 16'h0002; tick();
    mst_req = 16'h0003; ticks(3);

    // Slot limit forces a break; zero disables it.
    force_tag = "R6";
    set_acc(1, 1, 0, 0); cfg_slot_limit = 8'd3; ticks(10);
    cfg_slot_limit = 8'd1; ticks(6);
    cfg_slot_limit = 8'd0; ticks(12);

    // Fixed priority.
    force_tag = "R8";
    cfg_arb_alg = 1'b1; set_acc(1, 0, 0, 0); mst_req = 16'hC100; ticks(4);
    mst_req = 16'h8000; ticks(2);

    // Round-robin wrap.
    force_tag = "R7";
    cfg_arb_alg = 1'b0; mst_req = 16'h8001; ticks(4);
    mst_req = 16'h0124; ticks(5);

    // Default-master policies with no request.
    mst_req = '0; set_acc(0, 0, 0, 0);
    force_tag = "R10"; cfg_dflt_mode = 2'd1; cfg_dflt_idx = 4'd9; ticks(2);
    cfg_dflt_idx = 4'd3; ticks(2);
    force_tag = "R11"; cfg_dflt_mode = 2'd2; ticks(2);
    cfg_dflt_idx = 4'd14; ticks(2);
    force_tag = "R9"; cfg_dflt_mode = 2'd0; ticks(2);
    cfg_dflt_mode = 2'd3; ticks(2);
    force_tag = "";

    // Constrained random traffic.
    for (int c = 0; c < 6000; c++) begin
      if (c % 150 == 0) begin
        cfg_arb_alg    = 1'($urandom_range(0, 1));
        cfg_dflt_mode  = 2'($urandom_range(0, 3));
        cfg_dflt_idx   = 4'($urandom_range(0, 15));
        cfg_slot_limit = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(1, 6));
      end
      mst_req   = ($urandom_range(0, 4) == 0) ? '0 : (16'($urandom) & 16'($urandom));
      acc_busy  = ($urandom_range(0, 4) != 0);
      acc_burst = ($urandom_range(0, 3) != 0);
      acc_last  = ($urandom_range(0, 5) == 0);
      acc_undef = ($urandom_range(0, 3) == 0);
      tick();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule